// File: doc/BRIEF.md
# Serial Video Retimer Supervisor

This block is the synchronous control and status logic that sits beside a multi-rate serial video retimer. All of its logic runs on the 27 MHz reference clock. It decodes a 2-bit source code into four one-hot input-select lines. It measures the incoming line rate by counting prescaled data-transition pulses over a fixed window of reference cycles. It declares lock once the recovery loop reports lock and enough consecutive windows agree on a rate that the chosen rate mode accepts.

From lock and the operator controls, the block derives four things: the retimer bypass enable, separate mute enables for the primary and secondary outputs, the clock-or-data choice for the secondary output, and a registered SD/HD indicator. Muting takes priority over every bypass condition. The secondary output is also silenced whenever it carries the clock while the retimer is bypassed. Any change of the source or rate code drops lock and starts acquisition again from a fresh window.

Top module: `sdi_retimer_supervisor`

## Requirements
- R1: `in_sel` is one-hot: source code 00 drives bit 0, 01 drives bit 1, 10 drives bit 2, and 11 drives bit 3.
- R2: Rate code 00 (and the spare code 11) runs auto-detection and accepts the 143, 270 and HD classes. Code 01 accepts only the 270 class. Code 10 accepts only the HD class. The 143 class therefore never locks in a fixed mode.
- R3: `bypass_en` is high whenever `force_bypass` is high or `lock_det` is low, and low otherwise.
- R4: While `mute_n` is low, `mute_pri` and `mute_sec` are both high, whatever the bypass state.
- R5: `sec_is_clk` follows `clk_out_en`. `mute_sec` is also high when `clk_out_en` and `bypass_en` are both high.
- R6: Classification uses `edge_pulse` samples counted over WIN_CYCLES reference cycles. With W = WIN_CYCLES and integer division, a count in [W*8/100, W*10/100] is class 143, a count in [W*16/100, W*18/100] is class 270, and a count in [W*85/100, W*95/100] is class HD. A count of zero means no data. Any other count is unsupported. Neither no-data nor unsupported counts ever produce lock, so rates such as 177, 360 and 540 Mbit/s, and the 2x and 4x multiples of 270, leave the retimer bypassed.
- R7: Lock rises one cycle after the end of the window that completes ACQ_AUTO consecutive accepted windows of the same class in auto mode, or ACQ_FIXED such windows in a fixed mode. Windows restart at every code change.
- R8: `lock_det` falls on the first clock edge at which `loop_locked` is low. It also falls at the end of any window whose class is not accepted.
- R9: A change of `src_sel` or `rate_mode` clears `lock_det` on the next clock edge and restarts the rate window.
- R10: `sd_hd` is registered. It is low in any cycle in which `lock_det` is low. It is still low in the cycle in which lock first shows. It rises one cycle later if the locked class is 143 or 270, and stays low for HD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_sel | input | 2 | Source input code |
| rate_mode | input | 2 | Rate mode code (auto, fixed 270, fixed HD) |
| force_bypass | input | 1 | Forces the retimer path to be bypassed |
| mute_n | input | 1 | Output mute, active low |
| clk_out_en | input | 1 | Secondary output carries the clock when high |
| loop_locked | input | 1 | Lock flag from the clock recovery loop |
| edge_pulse | input | 1 | One prescaled data-transition event per reference cycle |
| in_sel | output | 4 | One-hot input-select lines |
| bypass_en | output | 1 | Bypass enable for the retimer path |
| mute_pri | output | 1 | Mute enable for the primary output |
| mute_sec | output | 1 | Mute enable for the secondary output |
| sec_is_clk | output | 1 | Secondary output selects the recovered clock |
| lock_det | output | 1 | Lock detect, active high |
| sd_hd | output | 1 | High for SD rates, low for HD or when unlocked |

## Verification
The bench builds the block with a 200-cycle window, three agreeing windows for auto acquisition and one for fixed modes. These values let full acquisition, window-boundary drops and the no-lock cases for off-band and harmonic rates run in a few hundred cycles each. With a 200-cycle window the class bands fall at integer counts 16–20, 32–36 and 170–190, so the transition densities the bench drives sit clearly inside or between the bands. The short acquisition also makes the exact lock-rise cycle and the one-cycle-late SD/HD update easy to measure.

// File: rtl/sdi_sup_pkg.sv
// Package: shared rate-class type and mode decode helpers for the
// retimer supervisor. Assumes a 2-bit rate-mode code.
package sdi_sup_pkg;

    typedef enum logic [2:0] {
        RC_NONE  = 3'd0,
        RC_SD143 = 3'd1,
        RC_SD270 = 3'd2,
        RC_HD    = 3'd3,
        RC_BAD   = 3'd4
    } rate_cls_t;

    localparam logic [1:0] RM_AUTO     = 2'b00;
    localparam logic [1:0] RM_FIX270   = 2'b01;
    localparam logic [1:0] RM_FIXHD    = 2'b10;
    localparam logic [1:0] RM_AUTO_ALT = 2'b11;

    // True when the rate mode runs auto-detection.
    function automatic logic mode_is_auto(logic [1:0] m);
        return (m == RM_AUTO) || (m == RM_AUTO_ALT);
    endfunction

    // True when class c may produce lock under rate mode m.
    function automatic logic cls_allowed(rate_cls_t c, logic [1:0] m);
        logic ok;
        case (m)
            RM_FIX270: ok = (c == RC_SD270);
            RM_FIXHD:  ok = (c == RC_HD);
            default:   ok = (c == RC_SD143) || (c == RC_SD270) || (c == RC_HD);
        endcase
        return ok;
    endfunction

    // True for the standard-definition classes.
    function automatic logic cls_is_sd(rate_cls_t c);
        return (c == RC_SD143) || (c == RC_SD270);
    endfunction

endpackage

// File: rtl/sdi_rate_meter.sv
// Module: counts edge_pulse samples over a window of WIN_CYCLES reference
// cycles and classifies the count against three bands derived from the
// window length. Publishes the class with a one-cycle done strobe.
// Assumes WIN_CYCLES >= 2; restart clears the window synchronously.
module sdi_rate_meter
    import sdi_sup_pkg::*;
#(
    parameter int WIN_CYCLES = 2700
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      edge_pulse,
    output rate_cls_t cls_o,
    output logic      win_done_o
);

    localparam int CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST    = CW'(WIN_CYCLES - 1);
    localparam logic [CW-1:0] B143_LO = CW'(WIN_CYCLES * 8 / 100);
    localparam logic [CW-1:0] B143_HI = CW'(WIN_CYCLES * 10 / 100);
    localparam logic [CW-1:0] B270_LO = CW'(WIN_CYCLES * 16 / 100);
    localparam logic [CW-1:0] B270_HI = CW'(WIN_CYCLES * 18 / 100);
    localparam logic [CW-1:0] BHD_LO  = CW'(WIN_CYCLES * 85 / 100);
    localparam logic [CW-1:0] BHD_HI  = CW'(WIN_CYCLES * 95 / 100);

    logic [CW-1:0] win_cnt;
    logic [CW-1:0] edge_cnt;
    logic [CW-1:0] total;
    rate_cls_t     cls_q;
    rate_cls_t     cls_new;
    logic          done_q;

    // Final count including this cycle's sample, and its class.
    always_comb begin
        total = edge_cnt + CW'(edge_pulse);
        if (total == '0)
            cls_new = RC_NONE;
        else if (total >= B143_LO && total <= B143_HI)
            cls_new = RC_SD143;
        else if (total >= B270_LO && total <= B270_HI)
            cls_new = RC_SD270;
        else if (total >= BHD_LO && total <= BHD_HI)
            cls_new = RC_HD;
        else
            cls_new = RC_BAD;
    end

    // Window counter, edge accumulator and class register.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            cls_q    <= RC_NONE;
            done_q   <= 1'b0;
        end else if (win_cnt == LAST) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            cls_q    <= cls_new;
            done_q   <= 1'b1;
        end else begin
            win_cnt  <= win_cnt + CW'(1);
            edge_cnt <= total;
            done_q   <= 1'b0;
        end
    end

    assign cls_o      = cls_q;
    assign win_done_o = done_q;

    p_done_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    p_count_within_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= win_cnt);

endmodule

// File: rtl/sdi_lock_ctrl.sv
// Module: acquisition and lock state. Counts consecutive accepted windows
// of one class, asserts lock after the mode's required count, drops it on
// loop loss, rejected windows or restart, and registers the SD/HD flag
// one cycle behind lock. Assumes ACQ_AUTO and ACQ_FIXED are at least 1.
module sdi_lock_ctrl
    import sdi_sup_pkg::*;
#(
    parameter int ACQ_AUTO  = 100,
    parameter int ACQ_FIXED = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       loop_locked,
    input  logic [1:0] rate_mode,
    input  logic       win_done,
    input  rate_cls_t  cls,
    output logic       lock_o,
    output logic       sd_o
);

    localparam int ACQ_MAX = (ACQ_AUTO > ACQ_FIXED) ? ACQ_AUTO : ACQ_FIXED;
    localparam int AW      = $clog2(ACQ_MAX + 1);
    localparam logic [AW-1:0] NEED_AUTO  = AW'(ACQ_AUTO);
    localparam logic [AW-1:0] NEED_FIXED = AW'(ACQ_FIXED);

    logic [AW-1:0] run_q, run_n;
    rate_cls_t     prev_q, prev_n;
    logic          lock_q, lock_n;
    logic          sd_q;
    logic [AW-1:0] need;

    // Required window count for the current mode.
    assign need = mode_is_auto(rate_mode) ? NEED_AUTO : NEED_FIXED;

    // Next-state for run length, held class and lock.
    always_comb begin
        run_n  = run_q;
        prev_n = prev_q;
        lock_n = lock_q;
        if (restart) begin
            run_n  = '0;
            prev_n = RC_NONE;
            lock_n = 1'b0;
        end else if (!loop_locked) begin
            run_n  = '0;
            lock_n = 1'b0;
        end else if (win_done) begin
            if (cls_allowed(cls, rate_mode)) begin
                if (cls == prev_q && run_q != '0)
                    run_n = (run_q >= need) ? run_q : run_q + AW'(1);
                else
                    run_n = AW'(1);
                lock_n = (run_n >= need);
            end else begin
                run_n  = '0;
                lock_n = 1'b0;
            end
            prev_n = cls;
        end
    end

    // State registers; SD flag follows lock by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            prev_q <= RC_NONE;
            lock_q <= 1'b0;
            sd_q   <= 1'b0;
        end else begin
            run_q  <= run_n;
            prev_q <= prev_n;
            lock_q <= lock_n;
            sd_q   <= lock_q && lock_n && cls_is_sd(prev_q);
        end
    end

    assign lock_o = lock_q;
    assign sd_o   = sd_q;

    p_sd_needs_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sd_q |-> lock_q);

    p_sd_late_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> !sd_q);

    p_lock_after_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(win_done));

    p_lock_class_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !restart) |-> cls_allowed(prev_q, rate_mode));

    p_loop_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_locked |=> !lock_q);

    p_restart_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !lock_q);

endmodule

// File: rtl/sdi_out_ctrl.sv
// Module: combinational output controls. Decodes the source code to
// one-hot select lines and forms bypass, mute and secondary-output
// selection from lock and the operator inputs. Mute dominates bypass.
module sdi_out_ctrl #(
    parameter int N_IN = 4,
    localparam int SELW = $clog2(N_IN)
) (
    input  logic [SELW-1:0] src_sel,
    input  logic            force_bypass,
    input  logic            mute_n,
    input  logic            clk_out_en,
    input  logic            locked,
    output logic [N_IN-1:0] in_sel,
    output logic            bypass_en,
    output logic            mute_pri,
    output logic            mute_sec,
    output logic            sec_is_clk
);

    // One select line per input.
    for (genvar g = 0; g < N_IN; g++) begin : g_sel
        assign in_sel[g] = (src_sel == SELW'(g));
    end

    // Bypass, mute and secondary-output selection.
    always_comb begin
        bypass_en  = force_bypass || !locked;
        mute_pri   = !mute_n;
        mute_sec   = !mute_n || (clk_out_en && bypass_en);
        sec_is_clk = clk_out_en;
    end

    always_comb begin
        p_sel_onehot_r1: assert ($onehot(in_sel));
    end

endmodule

// File: rtl/sdi_retimer_supervisor.sv
// Module: top of the retimer supervisor. Detects source/rate code changes,
// restarts measurement and acquisition on them, and ties rate meter, lock
// control and output control together. All logic runs on the reference
// clock; reset is synchronous and active low.
module sdi_retimer_supervisor
    import sdi_sup_pkg::*;
#(
    parameter int WIN_CYCLES = 2700,
    parameter int ACQ_AUTO   = 100,
    parameter int ACQ_FIXED  = 10,
    parameter int N_IN       = 4,
    localparam int SELW      = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] src_sel,
    input  logic [1:0]      rate_mode,
    input  logic            force_bypass,
    input  logic            mute_n,
    input  logic            clk_out_en,
    input  logic            loop_locked,
    input  logic            edge_pulse,
    output logic [N_IN-1:0] in_sel,
    output logic            bypass_en,
    output logic            mute_pri,
    output logic            mute_sec,
    output logic            sec_is_clk,
    output logic            lock_det,
    output logic            sd_hd
);

    localparam int CODEW = SELW + 2;

    logic [CODEW-1:0] code_q;
    logic             restart;
    rate_cls_t        cls;
    logic             win_done;

    // A code differing from the last registered one restarts acquisition.
    assign restart = ({src_sel, rate_mode} != code_q);

    // Remember the last seen code.
    always_ff @(posedge clk) begin
        code_q <= {src_sel, rate_mode};
    end

    sdi_rate_meter #(
        .WIN_CYCLES (WIN_CYCLES)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .edge_pulse (edge_pulse),
        .cls_o      (cls),
        .win_done_o (win_done)
    );

    sdi_lock_ctrl #(
        .ACQ_AUTO  (ACQ_AUTO),
        .ACQ_FIXED (ACQ_FIXED)
    ) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .loop_locked (loop_locked),
        .rate_mode   (rate_mode),
        .win_done    (win_done),
        .cls         (cls),
        .lock_o      (lock_det),
        .sd_o        (sd_hd)
    );

    sdi_out_ctrl #(
        .N_IN (N_IN)
    ) u_out (
        .src_sel      (src_sel),
        .force_bypass (force_bypass),
        .mute_n       (mute_n),
        .clk_out_en   (clk_out_en),
        .locked       (lock_det),
        .in_sel       (in_sel),
        .bypass_en    (bypass_en),
        .mute_pri     (mute_pri),
        .mute_sec     (mute_sec),
        .sec_is_clk   (sec_is_clk)
    );

    p_unlocked_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_det |-> bypass_en);

    p_mute_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_n |-> (mute_pri && mute_sec));

    p_sec_mute_reason_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_sec && !mute_pri) |-> (clk_out_en && bypass_en));

endmodule

// File: tb/sdi_retimer_supervisor_test.sv
module sdi_retimer_supervisor_test;

    localparam int CLK_T = 10;
    localparam int W     = 200;
    localparam int NA    = 3;
    localparam int NF    = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic [1:0] rate_mode = 2'b00;
    logic       force_bypass = 1'b0;
    logic       mute_n = 1'b1;
    logic       clk_out_en = 1'b0;
    logic       loop_locked = 1'b1;
    logic       edge_pulse = 1'b0;
    logic [3:0] in_sel;
    logic       bypass_en, mute_pri, mute_sec, sec_is_clk, lock_det, sd_hd;

    int dens = 0;
    int acc  = 0;
    int n_chk = 0;
    int n_bad = 0;

    sdi_retimer_supervisor #(
        .WIN_CYCLES (W),
        .ACQ_AUTO   (NA),
        .ACQ_FIXED  (NF),
        .N_IN       (4)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_sel      (src_sel),
        .rate_mode    (rate_mode),
        .force_bypass (force_bypass),
        .mute_n       (mute_n),
        .clk_out_en   (clk_out_en),
        .loop_locked  (loop_locked),
        .edge_pulse   (edge_pulse),
        .in_sel       (in_sel),
        .bypass_en    (bypass_en),
        .mute_pri     (mute_pri),
        .mute_sec     (mute_sec),
        .sec_is_clk   (sec_is_clk),
        .lock_det     (lock_det),
        .sd_hd        (sd_hd)
    );

    always #(CLK_T/2) clk = ~clk;

    // Transition pulses with an evenly spread density of dens per W cycles.
    initial begin
        forever begin
            @(negedge clk);
            acc = acc + dens;
            if (acc >= W) begin
                acc = acc - W;
                edge_pulse = 1'b1;
            end else begin
                edge_pulse = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_sel(input logic [1:0] s);
        return 4'b0001 << s;
    endfunction

    function automatic logic exp_byp(input logic fb, input logic lk);
        return fb || !lk;
    endfunction

    function automatic logic exp_msec(input logic mn, input logic ce, input logic byp);
        return !mn || (ce && byp);
    endfunction

    // Change to the given code (forcing a real change) and count cycles to lock.
    task automatic acquire(input logic [1:0] s, input logic [1:0] m, input int d,
                           input int limit, output int k);
        dens = d;
        if (s == src_sel && m == rate_mode) begin
            @(negedge clk);
            src_sel = s + 2'd1;
        end
        @(negedge clk);
        src_sel = s;
        rate_mode = m;
        k = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (lock_det) begin
                k = i;
                break;
            end
        end
    endtask

    // Lock then check exact rise cycle and the SD/HD flag one cycle later.
    task automatic lock_case(input logic [1:0] s, input logic [1:0] m, input int d,
                             input int need, input logic sd_exp, input string tag);
        int k;
        int lo;
        lo = need * W + 1;
        acquire(s, m, d, need * W + 20, k);
        check(k >= lo && k <= lo + 2, {tag, " R7 lock cycle"}, k, lo + 1);
        check(sd_hd == 1'b0, {tag, " R10 sd low at lock"}, int'(sd_hd), 0);
        check(bypass_en == 1'b0, {tag, " R3 no bypass when locked"}, int'(bypass_en), 0);
        @(negedge clk);
        check(sd_hd == sd_exp, {tag, " R10 sd after lock"}, int'(sd_hd), int'(sd_exp));
    endtask

    // Expect no lock and bypass over several windows.
    task automatic nolock_case(input logic [1:0] m, input int d, input string tag);
        int k;
        acquire(2'd1, m, d, 4 * W + 4, k);
        check(k == 0, {tag, " R6 no lock"}, k, 0);
        check(bypass_en == 1'b1, {tag, " R3 bypass unlocked"}, int'(bypass_en), 1);
        check(sd_hd == 1'b0, {tag, " R10 sd low unlocked"}, int'(sd_hd), 0);
    endtask

    initial begin
        #(CLK_T * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k;
        void'($urandom(32'd7361));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check(lock_det == 1'b0, "R8 reset lock low", int'(lock_det), 0);
        check(sd_hd == 1'b0, "R10 reset sd low", int'(sd_hd), 0);
        check(bypass_en == 1'b1, "R3 reset bypass", int'(bypass_en), 1);
        check(in_sel == 4'b0001, "R1 reset select", int'(in_sel), 1);

        // R1: select decode for every code
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            src_sel = 2'(s);
            #1;
            check(in_sel == exp_sel(2'(s)), "R1 select decode", int'(in_sel), int'(exp_sel(2'(s))));
        end

        // Auto mode, each supported class
        lock_case(2'd0, 2'b00, 180, NA, 1'b0, "auto HD");
        lock_case(2'd1, 2'b00, 34,  NA, 1'b1, "auto 270");
        lock_case(2'd2, 2'b00, 18,  NA, 1'b1, "auto 143");
        lock_case(2'd3, 2'b11, 34,  NA, 1'b1, "R2 spare code auto");

        // Fixed modes
        lock_case(2'd0, 2'b01, 34,  NF, 1'b1, "R2 fixed 270");
        lock_case(2'd1, 2'b10, 180, NF, 1'b0, "R2 fixed HD");
        nolock_case(2'b01, 18,  "R2 fixed 270 rejects 143");
        nolock_case(2'b10, 34,  "R2 fixed HD rejects 270");

        // Unsupported rates and harmonics in auto mode
        nolock_case(2'b00, 22,  "177 rate");
        nolock_case(2'b00, 44,  "360 rate");
        nolock_case(2'b00, 66,  "540 rate");
        nolock_case(2'b00, 131, "4x 270 rate");
        nolock_case(2'b00, 0,   "no data");

        // R8: loop loss drops lock and sd on the next edge
        lock_case(2'd2, 2'b00, 34, NA, 1'b1, "pre loop loss");
        @(negedge clk);
        loop_locked = 1'b0;
        @(negedge clk);
        check(lock_det == 1'b0, "R8 loop loss lock", int'(lock_det), 0);
        check(sd_hd == 1'b0, "R10 loop loss sd", int'(sd_hd), 0);
        check(bypass_en == 1'b1, "R3 loop loss bypass", int'(bypass_en), 1);
        loop_locked = 1'b1;

        // R8: off-band window drops lock
        lock_case(2'd2, 2'b00, 34, NA, 1'b1, "pre rate shift");
        dens = 44;
        k = 0;
        for (int i = 1; i <= 2 * W + 4; i++) begin
            @(negedge clk);
            if (!lock_det) begin
                k = i;
                break;
            end
        end
        check(k != 0, "R8 off-band window unlocks", k, 1);

        // R9: code change clears lock next edge
        lock_case(2'd1, 2'b00, 180, NA, 1'b0, "pre code change");
        @(negedge clk);
        src_sel = 2'd3;
        @(negedge clk);
        check(lock_det == 1'b0, "R9 code change unlock", int'(lock_det), 0);
        check(in_sel == 4'b1000, "R1 new select", int'(in_sel), 8);

        // Random controls while locked at an SD rate (R3, R4, R5)
        lock_case(2'd0, 2'b00, 34, NA, 1'b1, "pre random");
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            mute_n       = 1'($urandom_range(0, 3) != 0);
            force_bypass = 1'($urandom_range(0, 1));
            clk_out_en   = 1'($urandom_range(0, 1));
            #1;
            check(lock_det == 1'b1, "R7 lock held", int'(lock_det), 1);
            check(bypass_en == exp_byp(force_bypass, lock_det), "R3 bypass",
                  int'(bypass_en), int'(exp_byp(force_bypass, lock_det)));
            check(mute_pri == !mute_n, "R4 primary mute", int'(mute_pri), int'(!mute_n));
            check(mute_sec == exp_msec(mute_n, clk_out_en, bypass_en), "R5 secondary mute",
                  int'(mute_sec), int'(exp_msec(mute_n, clk_out_en, bypass_en)));
            check(sec_is_clk == clk_out_en, "R5 clock select", int'(sec_is_clk), int'(clk_out_en));
        end

        // Directed: mute dominates with forced bypass, unlocked clock output
        @(negedge clk);
        mute_n = 1'b0;
        force_bypass = 1'b1;
        clk_out_en = 1'b0;
        #1;
        check(mute_pri && mute_sec, "R4 mute over bypass", int'({mute_pri, mute_sec}), 3);
        @(negedge clk);
        mute_n = 1'b1;
        loop_locked = 1'b0;
        clk_out_en = 1'b1;
        force_bypass = 1'b0;
        @(negedge clk);
        check(mute_sec == 1'b1 && mute_pri == 1'b0, "R5 clock muted in bypass",
              int'({mute_pri, mute_sec}), 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule